// File: doc/BRIEF.md
# Serial Port Interrupt Collector

This block gathers every interrupt condition of a synchronous serial port into one place. The FIFO and shifter logic outside it report fill levels, word-complete strobes, FIFO read strobes, a serial bit-period tick, DMA-done pulses and a transmit-drained level. From these it forms seven raw status bits. Two of them are sticky events: receive overrun, and receive idle timeout from its own timer. The rest follow their inputs directly.

A mask register selects which sources may reach the processor. The masked status is the raw status ANDed with the mask. A single interrupt line is the registered OR of the masked status. The sticky bits are cleared by a write-one-to-clear strobe. The block also holds the two DMA enable bits and turns the FIFO threshold conditions into DMA request lines.

Register writes arrive as single-cycle strobes that share one data bus. Software and the DMA engine read the status and request outputs directly.

Top module: `sspi_irq_ctrl`

## Requirements
- R1: Raw status bit positions: 0 receive overrun, 1 receive timeout, 2 receive level, 3 transmit level, 4 receive DMA done, 5 transmit DMA done, 6 transmit drained.
- R2: Bit 2 is high while rx_level is 4 or more. Bit 3 is high while tx_level is 4 or less. The default depth is 8 entries.
- R3: masked_status equals raw_status AND mask. A write to the mask loads reg_wdata[6:0]. The mask resets to 0.
- R4: irq equals, one clock later, the OR of all masked_status bits.
- R5: Bit 0 sets when rx_word_done arrives while rx_level equals the FIFO depth. It stays set until cleared. A word that completes at a lower level does not set it.
- R6: Bit 1 sets after 32 bit_tick strobes with rx_level non-zero and no word or read in between. It is visible the cycle after the 32nd tick and stays set until cleared.
- R7: The timeout count restarts on rx_word_done, on rx_pop, or while rx_level is 0. A restart in the cycle of the 32nd tick prevents the set.
- R8: A clear strobe clears bit 0 where reg_wdata[0] is 1 and bit 1 where reg_wdata[1] is 1. Other data bits have no effect.
- R9: A clear in the same cycle as a set event leaves the bit set.
- R10: A DMA control write loads reg_wdata[0] as the receive enable and reg_wdata[1] as the transmit enable. rx_dma_req is the receive enable AND bit 2. tx_dma_req is the transmit enable AND bit 3.
- R11: Bits 4 and 5 follow the rx_dma_done and tx_dma_done pulses in the same cycle. Bit 6 follows tx_drained.
- R12: After reset the sticky bits, the mask, the DMA enables and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_level | input | 4 | Receive FIFO occupancy |
| tx_level | input | 4 | Transmit FIFO occupancy |
| rx_word_done | input | 1 | A received word completed this cycle |
| rx_pop | input | 1 | Receive FIFO read this cycle |
| bit_tick | input | 1 | One strobe per serial bit period |
| rx_dma_done | input | 1 | Receive DMA finished pulse |
| tx_dma_done | input | 1 | Transmit DMA finished pulse |
| tx_drained | input | 1 | Transmit FIFO and shifter empty |
| wr_mask | input | 1 | Load mask from reg_wdata |
| wr_clear | input | 1 | Write-one-to-clear strobe |
| wr_dmactl | input | 1 | Load DMA enables from reg_wdata |
| reg_wdata | input | 8 | Register write data |
| raw_status | output | 7 | Raw source status |
| mask_bits | output | 7 | Mask register |
| masked_status | output | 7 | Raw status AND mask |
| irq | output | 1 | Combined registered interrupt |
| dma_en | output | 2 | DMA enables, bit 0 receive, bit 1 transmit |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is the edge of the timeout window. One stimulus run stops one tick short of expiry. Another lands a FIFO read exactly in the cycle of the 32nd tick. Both need the FIFO held non-empty with ticks issued cycle by cycle. The bench drives long tick runs with the read strobe placed on a chosen cycle. It also places a clear strobe on the same edge as an overrun-producing word, to exercise the set-over-clear priority.

// File: rtl/sspi_irq_pkg.sv
package sspi_irq_pkg;
   localparam int NSRC    = 7;
   localparam int B_RXOVR = 0;
   localparam int B_RXTMO = 1;
   localparam int B_RXLVL = 2;
   localparam int B_TXLVL = 3;
   localparam int B_RXDMA = 4;
   localparam int B_TXDMA = 5;
   localparam int B_TXEOT = 6;
   localparam int NSTICKY = 2;
   localparam int DMA_RX  = 0;
   localparam int DMA_TX  = 1;
endpackage

// File: rtl/sspi_sticky_flag.sv
module sspi_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i) |=> q);
endmodule

// File: rtl/sspi_rx_idle_timer.sv
module sspi_rx_idle_timer #(
   parameter int LIMIT = 32,
   parameter int LW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rx_level,
   input  logic          word_done,
   input  logic          rd_pop,
   input  logic          bit_tick,
   output logic          expire
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;
   logic          restart;

   assign restart = (rx_level == '0) || word_done || rd_pop;
   assign expire  = !restart && bit_tick && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cnt <= '0;
      else if (restart)                           cnt <= '0;
      else if (bit_tick && cnt != CW'(LIMIT))     cnt <= cnt + 1'b1;
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT));
   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
endmodule

// File: rtl/sspi_irq_ctrl.sv
module sspi_irq_ctrl
   import sspi_irq_pkg::*;
#(
   parameter  int FIFO_DEPTH = 8,
   parameter  int IDLE_BITS  = 32,
   localparam int LW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LW-1:0]   rx_level,
   input  logic [LW-1:0]   tx_level,
   input  logic            rx_word_done,
   input  logic            rx_pop,
   input  logic            bit_tick,
   input  logic            rx_dma_done,
   input  logic            tx_dma_done,
   input  logic            tx_drained,
   input  logic            wr_mask,
   input  logic            wr_clear,
   input  logic            wr_dmactl,
   input  logic [7:0]      reg_wdata,
   output logic [NSRC-1:0] raw_status,
   output logic [NSRC-1:0] mask_bits,
   output logic [NSRC-1:0] masked_status,
   output logic            irq,
   output logic [1:0]      dma_en,
   output logic            rx_dma_req,
   output logic            tx_dma_req
);
   localparam int HALF = FIFO_DEPTH / 2;

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH % 2) != 0)
         $error("FIFO_DEPTH must be even and at least 2");
      if (IDLE_BITS < 2)
         $error("IDLE_BITS must be at least 2");
   endgenerate

   logic [NSTICKY-1:0] st_set, st_clr, st_q;
   logic               tmo_expire;
   logic               rx_half, tx_half;

   sspi_rx_idle_timer #(.LIMIT(IDLE_BITS), .LW(LW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_level  (rx_level),
      .word_done (rx_word_done),
      .rd_pop    (rx_pop),
      .bit_tick  (bit_tick),
      .expire    (tmo_expire)
   );

   assign st_set[B_RXOVR] = rx_word_done && (rx_level == LW'(FIFO_DEPTH));
   assign st_set[B_RXTMO] = tmo_expire;

   for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
      assign st_clr[i] = wr_clear && reg_wdata[i];
      sspi_sticky_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (st_set[i]),
         .clr_i (st_clr[i]),
         .q     (st_q[i])
      );
   end

   assign rx_half = (rx_level >= LW'(HALF));
   assign tx_half = (tx_level <= LW'(HALF));

   always_comb begin
      raw_status          = '0;
      raw_status[B_RXOVR] = st_q[B_RXOVR];
      raw_status[B_RXTMO] = st_q[B_RXTMO];
      raw_status[B_RXLVL] = rx_half;
      raw_status[B_TXLVL] = tx_half;
      raw_status[B_RXDMA] = rx_dma_done;
      raw_status[B_TXDMA] = tx_dma_done;
      raw_status[B_TXEOT] = tx_drained;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_bits <= '0;
         dma_en    <= '0;
         irq       <= 1'b0;
      end else begin
         if (wr_mask)   mask_bits <= reg_wdata[NSRC-1:0];
         if (wr_dmactl) dma_en    <= reg_wdata[1:0];
         irq <= |masked_status;
      end
   end

   assign masked_status = raw_status & mask_bits;
   assign rx_dma_req    = dma_en[DMA_RX] && rx_half;
   assign tx_dma_req    = dma_en[DMA_TX] && tx_half;

   p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|masked_status) |=> irq);
   p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|masked_status) |=> !irq);
   p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word_done && rx_level == LW'(FIFO_DEPTH)) |=> raw_status[B_RXOVR]);
   p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_bits == $past(reg_wdata[NSRC-1:0])));
endmodule

// File: tb/sspi_irq_ctrl_test.sv
module sspi_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int LIMIT = 32;

   logic clk = 0, rst_n = 0;
   logic [3:0] rx_level = 0, tx_level = 0;
   logic rx_word_done = 0, rx_pop = 0, bit_tick = 0;
   logic rx_dma_done = 0, tx_dma_done = 0, tx_drained = 0;
   logic wr_mask = 0, wr_clear = 0, wr_dmactl = 0;
   logic [7:0] reg_wdata = 0;
   logic [6:0] raw_status, mask_bits, masked_status;
   logic irq, rx_dma_req, tx_dma_req;
   logic [1:0] dma_en;

   int checks = 0, errors = 0;
   int m_ovr = 0, m_tmo = 0, m_cnt = 0, m_mask = 0, m_dma = 0, m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sspi_irq_ctrl uut (.*);

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int mraw();
      int r = 0;
      r |= m_ovr;
      r |= m_tmo << 1;
      if (rx_level >= DEPTH/2) r |= 4;
      if (tx_level <= DEPTH/2) r |= 8;
      if (rx_dma_done) r |= 16;
      if (tx_dma_done) r |= 32;
      if (tx_drained)  r |= 64;
      return r;
   endfunction

   task automatic compare();
      int r = mraw();
      chk(raw_status == 7'(r), "R1 raw", raw_status, r);
      chk(masked_status == 7'(r & m_mask), "R3 masked", masked_status, r & m_mask);
      chk(irq == 1'(m_irq), "R4 irq", irq, m_irq);
      chk(dma_en == 2'(m_dma), "R10 dma_en", dma_en, m_dma);
      chk(rx_dma_req == ((m_dma & 1) != 0 && (r & 4) != 0), "R10 rx_req", rx_dma_req, 0);
      chk(tx_dma_req == ((m_dma & 2) != 0 && (r & 8) != 0), "R10 tx_req", tx_dma_req, 0);
   endtask

   task automatic tick();
      int r, restart, ovr_set, tmo_set, nc;
      @(posedge clk);
      r = mraw();
      restart = (rx_level == 0) || rx_word_done || rx_pop;
      tmo_set = !restart && bit_tick && m_cnt == LIMIT - 1;
      ovr_set = rx_word_done && rx_level == DEPTH;
      nc = restart ? 0 : ((bit_tick && m_cnt != LIMIT) ? m_cnt + 1 : m_cnt);
      m_irq = ((r & m_mask) != 0);
      if (ovr_set) m_ovr = 1; else if (wr_clear && reg_wdata[0]) m_ovr = 0;
      if (tmo_set) m_tmo = 1; else if (wr_clear && reg_wdata[1]) m_tmo = 0;
      m_cnt = nc;
      if (wr_mask) m_mask = reg_wdata[6:0];
      if (wr_dmactl) m_dma = reg_wdata[1:0];
      @(negedge clk);
      compare();
   endtask

   task automatic wreg(input int which, input logic [7:0] d);
      reg_wdata = d;
      wr_mask = (which == 0); wr_clear = (which == 1); wr_dmactl = (which == 2);
      tick();
      wr_mask = 0; wr_clear = 0; wr_dmactl = 0; reg_wdata = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(raw_status[1:0] == 0 && mask_bits == 0 && dma_en == 0 && irq == 0,
          "R12 reset", {raw_status, mask_bits}, 0);
      rst_n = 1;
      tick();
      chk(irq == 0, "R12 irq after reset", irq, 0);

      wreg(0, 8'h7F);
      chk(mask_bits == 7'h7F, "R3 mask load", mask_bits, 7'h7F);
      tick();

      // R2 thresholds
      for (int i = 0; i <= DEPTH; i++) begin
         rx_level = 4'(i); tx_level = 4'(DEPTH - i);
         tick();
         chk(raw_status[2] == (i >= 4), "R2 rx level", raw_status[2], i >= 4);
         chk(raw_status[3] == ((DEPTH - i) <= 4), "R2 tx level", raw_status[3], (DEPTH - i) <= 4);
      end

      // R5 overrun
      rx_level = 7; rx_word_done = 1; tick(); rx_word_done = 0;
      chk(raw_status[0] == 0, "R5 no overrun below full", raw_status[0], 0);
      rx_level = 8; rx_word_done = 1; tick(); rx_word_done = 0;
      chk(raw_status[0] == 1, "R5 overrun set", raw_status[0], 1);
      rx_level = 3; repeat (3) tick();
      chk(raw_status[0] == 1, "R5 overrun sticky", raw_status[0], 1);

      // R8 clear ignores other bits
      wreg(1, 8'hFC);
      chk(raw_status[0] == 1, "R8 other bits ignored", raw_status[0], 1);
      wreg(1, 8'h01);
      chk(raw_status[0] == 0, "R8 clear overrun", raw_status[0], 0);

      // R9 set wins over clear
      rx_level = 8; rx_word_done = 1; reg_wdata = 8'h01; wr_clear = 1;
      tick();
      rx_word_done = 0; wr_clear = 0; reg_wdata = 0;
      chk(raw_status[0] == 1, "R9 set wins", raw_status[0], 1);
      wreg(1, 8'h01);

      // R6 timeout window
      rx_level = 2; bit_tick = 1;
      repeat (LIMIT - 1) tick();
      chk(raw_status[1] == 0, "R6 not yet at 31", raw_status[1], 0);
      rx_pop = 1; tick(); rx_pop = 0;
      chk(raw_status[1] == 0, "R7 read on 32nd tick blocks", raw_status[1], 0);
      repeat (LIMIT - 1) tick();
      chk(raw_status[1] == 0, "R7 restarted by read", raw_status[1], 0);
      tick();
      chk(raw_status[1] == 1, "R6 timeout set", raw_status[1], 1);
      bit_tick = 0;
      wreg(1, 8'h02);
      chk(raw_status[1] == 0, "R8 clear timeout", raw_status[1], 0);

      // R7 empty fifo does not count
      rx_level = 0; bit_tick = 1;
      repeat (LIMIT + 4) tick();
      chk(raw_status[1] == 0, "R7 empty no count", raw_status[1], 0);
      rx_level = 1; repeat (LIMIT/2) tick();
      rx_word_done = 1; tick(); rx_word_done = 0;
      repeat (LIMIT - 1) tick();
      chk(raw_status[1] == 0, "R7 word restarts", raw_status[1], 0);
      tick();
      chk(raw_status[1] == 1, "R6 set after word restart", raw_status[1], 1);
      bit_tick = 0;
      wreg(1, 8'h03);

      // R3/R4 partial mask
      wreg(0, 8'h40);
      rx_level = 6; tx_level = 2; tx_drained = 0; tick(); tick();
      chk(irq == 0, "R4 masked source no irq", irq, 0);
      tx_drained = 1; tick();
      chk(masked_status == 7'h40, "R3 masked only eot", masked_status, 7'h40);
      tick();
      chk(irq == 1, "R4 irq follows", irq, 1);

      // R11 DMA done pulses
      wreg(0, 8'h30); tx_drained = 0;
      rx_dma_done = 1; tick(); rx_dma_done = 0;
      tx_dma_done = 1; tick(); tx_dma_done = 0;
      tick(); tick();
      chk(irq == 0, "R11 pulse gone", irq, 0);

      // R10 DMA enables
      wreg(2, 8'h01);
      chk(rx_dma_req == 1 && tx_dma_req == 0, "R10 rx only", {rx_dma_req, tx_dma_req}, 2);
      wreg(2, 8'h02);
      chk(rx_dma_req == 0 && tx_dma_req == 1, "R10 tx only", {rx_dma_req, tx_dma_req}, 1);
      rx_level = 1; tx_level = 7; tick();
      chk(tx_dma_req == 0, "R10 tx above half", tx_dma_req, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule